// File: doc/BRIEF.md
# Charger LED and Buzzer Annunciator

This block turns the transmitter's status flags into drive for a red LED, a green LED and a piezo buzzer. The flags are standby, power transfer, charge complete, fault and foreign-object error. When more than one is raised, a fixed priority picks the one that is shown. A parameterised divider makes a quarter-millisecond tick from the system clock. All blink and tone timing is counted in these ticks.

After reset the block takes the first ADC sample that arrives and splits it into equal-width bins. It keeps the resulting configuration mode until the next reset. The mode only decides whether standby shows both LEDs lit or both dark.

The buzzer is a square wave that toggles on every tick. In power transfer it sounds one short tone at the start of the green blink. During a foreign-object error its tones line up exactly with the red on-phases. The tone runs for one group of blink periods, and the next group of the same length is silent while the red LED keeps blinking.

Top module: `status_annunciator`

## Requirements
- R1: While reset is held, and after it is released, `led_red`, `led_green` and `buzz` are low while no status flag is raised. Until an ADC sample has been taken, the configuration mode is 0.
- R2: Only the first cycle with `adc_valid` high after reset sets the configuration mode. Later samples leave the mode unchanged.
- R3: The mode is the ADC code shifted right by ADC_W-BIN_W bits. A bin value of 2 or more is unsupported and gives mode 0. In standby, mode 1 lights both LEDs and mode 0 leaves both dark.
- R4: Priority, highest first: foreign-object error, fault, charge complete, power transfer, standby. The LEDs and buzzer show the highest flag that is raised.
- R5: The outputs follow a flag change in the next cycle, and every pattern starts at its phase 0. In power transfer the green LED is on for SLOW_HALF ticks and off for SLOW_HALF ticks, repeating. The red LED is off.
- R6: In a foreign-object error the red LED is on for FAST_ON ticks and off for FAST_OFF ticks, repeating. The green LED is off.
- R7: On entering power transfer, `buzz` sounds for PT_TONE ticks starting in the same cycle as the first green on-phase. It is low in the first tick and then toggles every tick. After that it stays silent for the rest of that stay in power transfer.
- R8: In a foreign-object error, `buzz` toggles every tick during the red on-phase of the first ENV_CYCLES blink periods, starting low. It is silent for the next ENV_CYCLES periods while red keeps blinking, and this envelope repeats. `buzz` is never high while red is off.
- R9: Fault shows steady red, and charge complete shows steady green. `buzz` stays low in standby, fault, charge complete and idle.
- R10: When the foreign-object error clears, `buzz` and the red blink stop from the next cycle. A new error restarts the blink and envelope from phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_valid | input | 1 | ADC sample strobe |
| adc_code | input | ADC_W | ADC sample of the configuration sense voltage |
| st_standby | input | 1 | Standby status |
| st_power | input | 1 | Power transfer status |
| st_done | input | 1 | Charge complete status |
| st_fault | input | 1 | Fault status |
| st_fod | input | 1 | Foreign-object error status |
| led_red | output | 1 | Red LED enable |
| led_green | output | 1 | Green LED enable |
| buzz | output | 1 | Buzzer drive |

## Verification
A phase counter that is out of step shows up as a red or green edge in the wrong cycle within one blink period. An envelope counter that is off by one shows up as a missing or extra tone burst by the end of the first envelope. A divider or tone toggle that is slipped changes the `buzz` level within two ticks of a tone start. A wrongly latched mode changes the LEDs in the first standby cycle, and a priority fault changes them in the cycle after the flags combine.

// File: rtl/status_annunciator.sv
module status_annunciator #(
  parameter int TICK_DIV   = 50000,
  parameter int SLOW_HALF  = 4000,
  parameter int FAST_ON    = 1600,
  parameter int FAST_OFF   = 3200,
  parameter int ENV_CYCLES = 25,
  parameter int PT_TONE    = 1600,
  parameter int ADC_W      = 10,
  parameter int BIN_W      = 3,
  parameter int MODES      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adc_valid,
  input  logic [ADC_W-1:0] adc_code,
  input  logic             st_standby,
  input  logic             st_power,
  input  logic             st_done,
  input  logic             st_fault,
  input  logic             st_fod,
  output logic             led_red,
  output logic             led_green,
  output logic             buzz
);
  localparam int FAST_P = FAST_ON + FAST_OFF;
  localparam int SLOW_P = 2 * SLOW_HALF;
  localparam int MAXP   = (FAST_P > SLOW_P) ? FAST_P : SLOW_P;
  localparam int PH_W   = $clog2(MAXP + 1);
  localparam int DIV_W  = $clog2(TICK_DIV);
  localparam int REP_W  = $clog2(2 * ENV_CYCLES);
  localparam int SHIFT  = ADC_W - BIN_W;

  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
  localparam logic [PH_W-1:0]  FP_LAST  = PH_W'(FAST_P - 1);
  localparam logic [PH_W-1:0]  SP_LAST  = PH_W'(SLOW_P - 1);
  localparam logic [PH_W-1:0]  FON      = PH_W'(FAST_ON);
  localparam logic [PH_W-1:0]  SHALF    = PH_W'(SLOW_HALF);
  localparam logic [PH_W-1:0]  PTT      = PH_W'(PT_TONE);
  localparam logic [REP_W-1:0] ENVC     = REP_W'(ENV_CYCLES);
  localparam logic [REP_W-1:0] ENV_LAST = REP_W'(2 * ENV_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_STBY, S_PWR, S_DONE, S_FLT, S_FOD} state_t;

  state_t eff, st_q;
  logic [DIV_W-1:0] div_q;
  logic [PH_W-1:0]  ph;
  logic [REP_W-1:0] rep;
  logic             tog, cfg_done;
  logic [BIN_W-1:0] mode_q;
  logic [ADC_W-1:0] code_sh;
  logic             restart, tick, wrap, tone, lit;

  always_comb begin
    if (st_fod)          eff = S_FOD;
    else if (st_fault)   eff = S_FLT;
    else if (st_done)    eff = S_DONE;
    else if (st_power)   eff = S_PWR;
    else if (st_standby) eff = S_STBY;
    else                 eff = S_IDLE;
  end

  assign restart = eff != st_q;
  assign tick    = div_q == DIV_LAST;
  assign wrap    = tick && (ph == ((st_q == S_FOD) ? FP_LAST : SP_LAST));
  assign tone    = ((st_q == S_FOD) && (ph < FON) && (rep < ENVC)) ||
                   ((st_q == S_PWR) && (rep == '0) && (ph < PTT));
  assign code_sh = adc_code >> SHIFT;
  assign lit     = mode_q == BIN_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      div_q <= '0;
      ph    <= '0;
      rep   <= '0;
      tog   <= 1'b0;
    end else begin
      st_q <= eff;
      if (restart) begin
        div_q <= '0;
        ph    <= '0;
        rep   <= '0;
        tog   <= 1'b0;
      end else begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) ph <= wrap ? '0 : ph + 1'b1;
        if (wrap) begin
          if (st_q == S_FOD) rep <= (rep == ENV_LAST) ? '0 : rep + 1'b1;
          else if (rep == '0) rep <= REP_W'(1);
        end
        tog <= tone ? (tick ? ~tog : tog) : 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_done <= 1'b0;
      mode_q   <= '0;
    end else if (adc_valid && !cfg_done) begin
      cfg_done <= 1'b1;
      mode_q   <= (code_sh < ADC_W'(MODES)) ? code_sh[BIN_W-1:0] : '0;
    end
  end

  assign led_red   = ((st_q == S_FOD) && (ph < FON)) || (st_q == S_FLT) ||
                     ((st_q == S_STBY) && lit);
  assign led_green = (st_q == S_DONE) || ((st_q == S_PWR) && (ph < SHALF)) ||
                     ((st_q == S_STBY) && lit);
  assign buzz      = tone && tog;
endmodule

// File: rtl/annunciator_checker.sv
module annunciator_checker #(
  parameter int BIN_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             st_power,
  input logic             st_done,
  input logic             st_fault,
  input logic             st_fod,
  input logic             led_red,
  input logic             led_green,
  input logic             buzz,
  input logic             cfg_done,
  input logic [BIN_W-1:0] mode_q
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> !buzz && !led_red && !led_green);

  p_cfg_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> $stable(mode_q));

  p_fod_green_dark_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(st_fod) |-> !led_green);

  p_tone_on_red_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (buzz && $past(st_fod)) |-> led_red);

  p_fault_red_r9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(st_fault && !st_fod) |-> led_red && !led_green && !buzz);

  p_done_green_r9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(st_done && !st_fault && !st_fod) |-> led_green && !led_red && !buzz);

  p_silent_states_r10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(!st_fod && !(st_power && !st_fault && !st_done)) |-> !buzz);
endmodule

bind status_annunciator annunciator_checker #(.BIN_W(BIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_power(st_power), .st_done(st_done),
  .st_fault(st_fault), .st_fod(st_fod), .led_red(led_red),
  .led_green(led_green), .buzz(buzz), .cfg_done(cfg_done), .mode_q(mode_q)
);

// File: tb/sim_status_annunciator.sv
`timescale 1ns/1ps
module sim_status_annunciator;
  localparam int TD = 2, SH = 6, FON = 4, FOFF = 8, ENV = 2, PT = 4;
  localparam int FP = FON + FOFF, SP = 2 * SH;

  logic clk = 1'b0, rst_n = 1'b0, adc_valid = 1'b0;
  logic [7:0] adc_code = '0;
  logic st_standby = 0, st_power = 0, st_done = 0, st_fault = 0, st_fod = 0;
  logic led_red, led_green, buzz;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  status_annunciator #(.TICK_DIV(TD), .SLOW_HALF(SH), .FAST_ON(FON), .FAST_OFF(FOFF),
    .ENV_CYCLES(ENV), .PT_TONE(PT), .ADC_W(8), .BIN_W(3), .MODES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid), .adc_code(adc_code),
    .st_standby(st_standby), .st_power(st_power), .st_done(st_done),
    .st_fault(st_fault), .st_fod(st_fod), .led_red(led_red),
    .led_green(led_green), .buzz(buzz));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setin(input logic fod, flt, done, pwr, stby);
    st_fod = fod; st_fault = flt; st_done = done; st_power = pwr; st_standby = stby;
  endtask

  task automatic do_reset();
    setin(0, 0, 0, 0, 0);
    adc_valid = 0;
    rst_n = 0;
    step(3);
    chk("R1 reset red", led_red, 0);
    chk("R1 reset buzz", buzz, 0);
    rst_n = 1;
    step(1);
  endtask

  task automatic load_cfg(input logic [7:0] code);
    adc_code = code; adc_valid = 1;
    step(1);
    adc_valid = 0;
  endtask

  function automatic int fod_red(input int j);
    return ((j / TD) % FP) < FON;
  endfunction
  function automatic int fod_buzz(input int j);
    int t = j / TD;
    int ph = t % FP;
    int per = (t / FP) % (2 * ENV);
    return (ph < FON) && (per < ENV) && (ph % 2 == 1);
  endfunction

  task automatic t_reset();
    do_reset();
    chk("R1 idle red", led_red, 0);
    chk("R1 idle green", led_green, 0);
    chk("R1 idle buzz", buzz, 0);
    setin(0, 0, 0, 0, 1);
    step(1);
    chk("R1 standby dark before sample", led_red | led_green, 0);
  endtask

  task automatic t_config();
    do_reset();
    load_cfg(8'h20);
    setin(0, 0, 0, 0, 1);
    step(1);
    chk("R3 mode1 red lit", led_red, 1);
    chk("R3 mode1 green lit", led_green, 1);
    chk("R9 standby no buzz", buzz, 0);
    load_cfg(8'h00);
    step(2);
    chk("R2 second sample ignored", led_red & led_green, 1);
    do_reset();
    load_cfg(8'hA0);
    setin(0, 0, 0, 0, 1);
    step(1);
    chk("R3 bin5 unsupported", led_red | led_green, 0);
    do_reset();
    load_cfg(8'h40);
    setin(0, 0, 0, 0, 1);
    step(1);
    chk("R3 bin2 unsupported", led_red | led_green, 0);
    do_reset();
    load_cfg(8'h3F);
    setin(0, 0, 0, 0, 1);
    step(1);
    chk("R3 bin1 top code", led_red & led_green, 1);
    do_reset();
    load_cfg(8'h1F);
    setin(0, 0, 0, 0, 1);
    step(1);
    chk("R3 bin0 dark", led_red | led_green, 0);
  endtask

  task automatic t_power();
    do_reset();
    load_cfg(8'h20);
    setin(0, 0, 0, 1, 1);
    step(1);
    for (int j = 0; j < 60; j++) begin
      int t = j / TD;
      chk("R5 power green", led_green, (t % SP) < SH);
      chk("R4 power beats standby red", led_red, 0);
      chk("R7 power entry tone", buzz, (t < PT) && (t % 2 == 1));
      step(1);
    end
  endtask

  task automatic t_steady();
    do_reset();
    setin(0, 0, 1, 1, 0);
    step(1);
    for (int j = 0; j < 8; j++) begin
      chk("R9 done green", led_green, 1);
      chk("R9 done red", led_red, 0);
      chk("R9 done buzz", buzz, 0);
      step(1);
    end
    setin(0, 1, 1, 1, 0);
    step(1);
    for (int j = 0; j < 8; j++) begin
      chk("R9 fault red", led_red, 1);
      chk("R4 fault beats done", led_green, 0);
      chk("R9 fault buzz", buzz, 0);
      step(1);
    end
  endtask

  task automatic t_fod();
    do_reset();
    setin(1, 0, 0, 0, 0);
    step(1);
    for (int j = 0; j < 200; j++) begin
      chk("R6 fod red blink", led_red, fod_red(j));
      chk("R8 fod tone envelope", buzz, fod_buzz(j));
      chk("R6 fod green off", led_green, 0);
      step(1);
    end
  endtask

  task automatic t_clear();
    do_reset();
    setin(1, 0, 0, 0, 0);
    step(1);
    for (int j = 0; j < 4; j++) begin
      chk("R8 tone before clear", buzz, fod_buzz(j));
      if (j < 3) step(1);
    end
    setin(0, 0, 0, 0, 0);
    step(1);
    chk("R10 buzz stops", buzz, 0);
    chk("R10 red stops", led_red, 0);
    step(3);
    setin(1, 0, 0, 0, 0);
    step(1);
    for (int j = 0; j < 30; j++) begin
      chk("R10 restart red", led_red, fod_red(j));
      chk("R10 restart buzz", buzz, fod_buzz(j));
      step(1);
    end
  endtask

  task automatic t_priority();
    do_reset();
    load_cfg(8'h20);
    setin(1, 1, 1, 1, 1);
    step(1);
    for (int j = 0; j < 30; j++) begin
      chk("R4 fod over all red", led_red, fod_red(j));
      chk("R4 fod over all green", led_green, 0);
      chk("R4 fod over all buzz", buzz, fod_buzz(j));
      step(1);
    end
  endtask

  initial begin
    t_reset();
    t_config();
    t_power();
    t_steady();
    t_fod();
    t_clear();
    t_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule